// File: doc/BRIEF.md
# Debug DMA Access Sequencer

This block is a hardware master that performs memory accesses through a target's debug port. It does not drive a bus itself. The target exposes three registers: an address register, a data register and a control register. The sequencer reaches them over a register-exchange port. Each exchange selects one register and writes a 32-bit value into it. In the same exchange it gets back the value the register held before the write, as a scan chain returns it. The sequencer therefore works like a scripted debugger. It loads the address, loads the data for a write, and starts the access through the control register. It then polls until the target reports completion, collects the read data, and finally drops the access enable, which also reports whether the target saw a bus error.

A command carries a base address, an element size (byte, halfword or word), a direction, an element count and one write value. For multi-element writes the write value fills every element. The block places sub-word write data on every byte lane. It extracts the addressed lane from a read word. A failed element is retried from the address step up to a parameter limit. A poll that never finishes is cut off by a timeout. A failure of either kind ends the command. A persistent set of base control bits is ORed into every control-register value the block writes.

Top module: `dbg_dma_seq`

## Requirements
- R1: A read element issues exchanges in this order: address register (select 0) with the element address; control register (select 2) with the start value; one or more control polls; data register (select 1); then one control clearing write.
- R2: A write element issues exchanges in this order: address register with the element address; data register with the replicated write data; control start value; one or more control polls; then the control clearing write. There is no data-register exchange after the polls.
- R3: Control values are built from these bits: start at bit 0, read direction at bit 1, size code in bits 3:2 (0 byte, 1 halfword, 2 or 3 word), access enable at bit 4. The start value is base | enable | size | start | (read ? direction : 0). Every poll value is base | enable. The clearing value is base alone. Every control value contains all bits of `base_ctrl`.
- R4: Polling stops at the first returned control value whose bit 0 is clear. If POLL_LIMIT consecutive polls return bit 0 set, the block does the clearing write and then pulses `done` with `err_tmo`. It makes no retry, and the command ends.
- R5: If the value returned by the clearing write has bit 5 (error) set, the element restarts from the address step. Up to RETRY_MAX restarts are made. If the error persists after that, `done` pulses with `err_retry` and the command ends.
- R6: A halfword read returns data bits 31:16 when address bit 1 is set and bits 15:0 otherwise. The result is zero-extended.
- R7: A byte read returns the lane chosen by address bits 1:0: lane n is data bits 8n+7:8n. The result is zero-extended.
- R8: Write data is replicated before it is loaded: a byte into all four lanes, a halfword into both halves. A word is loaded unchanged.
- R9: Element k of a command uses address base + k × (1, 2 or 4 by size). A count of n performs n elements, and a count of 0 performs one. No element after a failed one is started.
- R10: A command is accepted only while `cmd_ready` is high. `cmd_valid` seen while busy is ignored.
- R11: `done` pulses for exactly one cycle per finished element. `rd_data` carries that element's read value in the same cycle, and is zero for writes and failed elements.
- R12: `xreq` stays high with `xsel` and `xwdata` unchanged until a cycle in which `xack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; a command is taken when both are high |
| cmd_addr | input | 32 | Address of the first element |
| cmd_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_count | input | CNT_W | Element count (0 acts as 1) |
| cmd_wdata | input | 32 | Fill value for write elements |
| base_ctrl | input | 32 | Persistent bits ORed into every control value |
| xreq | output | 1 | Exchange request |
| xsel | output | 2 | Register select: 0 address, 1 data, 2 control |
| xwdata | output | 32 | Value shifted into the selected register |
| xack | input | 1 | Exchange completes in a cycle with xreq and xack high |
| xrdata | input | 32 | Value shifted out, valid with xack |
| done | output | 1 | One-cycle pulse per finished element |
| rd_data | output | 32 | Extracted read value, valid with done |
| err_retry | output | 1 | With done: error persisted past the retry limit |
| err_tmo | output | 1 | With done: poll timed out |

## Verification
The bench sweeps every size and aligned lane offset in both directions against a behavioural target that answers with a varying acknowledge delay. A swapped lane selector would return the wrong byte, and a missing replication would corrupt neighbouring lanes of the target memory. The bench injects errors so that one retry limit succeeds on the last allowed attempt and another is exceeded by one; an off-by-one retry counter shows up as the wrong number of address exchanges or a wrong error flag. A target that never clears start must end after exactly POLL_LIMIT polls with a clearing write and no retry. A failure in the middle of a multi-element read must stop before the next address, and an extra poll after the first clear response is counted as a fault.

// File: rtl/dds_pkg.sv
package dds_pkg;

   localparam int unsigned DW    = 32;
   localparam int unsigned LANES = DW / 8;

   // control register bit positions, decoded by the target
   localparam int CB_START  = 0;
   localparam int CB_READ   = 1;
   localparam int CB_SIZE   = 2;
   localparam int CB_ENABLE = 4;
   localparam int CB_ERROR  = 5;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2
   } sel_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WDATA,
      ST_GO,
      ST_POLL,
      ST_RDATA,
      ST_CLEAR
   } state_e;

   function automatic logic [2:0] step_of(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: step_of = 3'd1;
         SZ_HALF: step_of = 3'd2;
         default: step_of = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dds_lanes.sv
module dds_lanes
   import dds_pkg::*;
(
   input  logic [1:0]    size,
   input  logic [1:0]    off,
   input  logic [DW-1:0] wr_in,
   input  logic [DW-1:0] raw,
   output logic [DW-1:0] wr_rep,
   output logic [DW-1:0] rd_ext
);

   // lane replication for writes
   for (genvar i = 0; i < LANES; i++) begin : g_rep
      always_comb begin
         case (size)
            SZ_BYTE: wr_rep[8*i +: 8] = wr_in[7:0];
            SZ_HALF: wr_rep[8*i +: 8] = wr_in[8*(i%2) +: 8];
            default: wr_rep[8*i +: 8] = wr_in[8*i +: 8];
         endcase
      end
   end

   // lane extraction for reads
   logic [7:0]  byte_lane [LANES];
   logic [15:0] half_pick;

   for (genvar i = 0; i < LANES; i++) begin : g_pick
      assign byte_lane[i] = raw[8*i +: 8];
   end

   assign half_pick = off[1] ? raw[31:16] : raw[15:0];

   always_comb begin
      case (size)
         SZ_BYTE: rd_ext = {24'd0, byte_lane[off]};
         SZ_HALF: rd_ext = {16'd0, half_pick};
         default: rd_ext = raw;
      endcase
   end

endmodule

// File: rtl/dds_seq.sv
module dds_seq
   import dds_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int RETRY_MAX  = 10,
   parameter int POLL_LIMIT = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [DW-1:0]    cmd_addr,
   input  logic [1:0]       cmd_size,
   input  logic             cmd_write,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic [DW-1:0]    cmd_wdata,
   input  logic [DW-1:0]    base_ctrl,
   output logic [1:0]       lane_size,
   output logic [1:0]       lane_off,
   output logic [DW-1:0]    lane_wdata,
   output logic [DW-1:0]    lane_raw,
   input  logic [DW-1:0]    wr_rep,
   input  logic [DW-1:0]    rd_ext,
   output logic             xreq,
   output logic [1:0]       xsel,
   output logic [DW-1:0]    xwdata,
   input  logic             xack,
   input  logic [DW-1:0]    xrdata,
   output logic             done,
   output logic [DW-1:0]    rd_data,
   output logic             err_retry,
   output logic             err_tmo
);

   localparam int RETRY_W = $clog2(RETRY_MAX + 2);
   localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
   localparam logic [RETRY_W-1:0] RETRY_TOP = RETRY_W'(RETRY_MAX);
   localparam logic [POLL_W-1:0]  POLL_LAST = POLL_W'(POLL_LIMIT - 1);
   localparam logic [DW-1:0]      EN_BIT    = DW'(1) << CB_ENABLE;
   localparam logic [DW-1:0]      GO_BIT    = DW'(1) << CB_START;
   localparam logic [DW-1:0]      RD_BIT    = DW'(1) << CB_READ;

   state_e             st_q;
   logic [DW-1:0]      addr_q, wdata_q, raw_q, rd_q;
   logic [1:0]         size_q;
   logic               wr_q;
   logic [CNT_W-1:0]   left_q;
   logic [RETRY_W-1:0] try_q;
   logic [POLL_W-1:0]  poll_q;
   logic               tmo_q, done_q, erty_q, etmo_q;
   logic               take;
   logic [DW-1:0]      go_word;

   assign take      = xreq && xack;
   assign xreq      = (st_q != ST_IDLE);
   assign cmd_ready = (st_q == ST_IDLE);

   assign lane_size  = size_q;
   assign lane_off   = addr_q[1:0];
   assign lane_wdata = wdata_q;
   assign lane_raw   = raw_q;

   assign go_word = base_ctrl | EN_BIT | GO_BIT
                  | (DW'(size_q) << CB_SIZE)
                  | (wr_q ? '0 : RD_BIT);

   always_comb begin
      case (st_q)
         ST_ADDR:  begin xsel = SEL_ADDR; xwdata = addr_q;             end
         ST_WDATA: begin xsel = SEL_DATA; xwdata = wr_rep;             end
         ST_GO:    begin xsel = SEL_CTRL; xwdata = go_word;            end
         ST_POLL:  begin xsel = SEL_CTRL; xwdata = base_ctrl | EN_BIT; end
         ST_RDATA: begin xsel = SEL_DATA; xwdata = '0;                 end
         ST_CLEAR: begin xsel = SEL_CTRL; xwdata = base_ctrl;          end
         default:  begin xsel = SEL_ADDR; xwdata = '0;                 end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         raw_q   <= '0;
         rd_q    <= '0;
         size_q  <= '0;
         wr_q    <= 1'b0;
         left_q  <= '0;
         try_q   <= '0;
         poll_q  <= '0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
         erty_q  <= 1'b0;
         etmo_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         erty_q <= 1'b0;
         etmo_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (cmd_valid) begin
               addr_q  <= cmd_addr;
               size_q  <= cmd_size;
               wr_q    <= cmd_write;
               wdata_q <= cmd_wdata;
               left_q  <= (cmd_count == '0) ? '0 : cmd_count - CNT_W'(1);
               try_q   <= '0;
               tmo_q   <= 1'b0;
               st_q    <= ST_ADDR;
            end
            ST_ADDR:  if (take) st_q <= wr_q ? ST_WDATA : ST_GO;
            ST_WDATA: if (take) st_q <= ST_GO;
            ST_GO: if (take) begin
               poll_q <= '0;
               st_q   <= ST_POLL;
            end
            ST_POLL: if (take) begin
               if (!xrdata[CB_START]) begin
                  st_q <= wr_q ? ST_CLEAR : ST_RDATA;
               end else if (poll_q == POLL_LAST) begin
                  tmo_q <= 1'b1;
                  st_q  <= ST_CLEAR;
               end else begin
                  poll_q <= poll_q + POLL_W'(1);
               end
            end
            ST_RDATA: if (take) begin
               raw_q <= xrdata;
               st_q  <= ST_CLEAR;
            end
            ST_CLEAR: if (take) begin
               if (tmo_q || (xrdata[CB_ERROR] && try_q == RETRY_TOP)) begin
                  done_q <= 1'b1;
                  etmo_q <= tmo_q;
                  erty_q <= !tmo_q;
                  rd_q   <= '0;
                  st_q   <= ST_IDLE;
               end else if (xrdata[CB_ERROR]) begin
                  try_q <= try_q + RETRY_W'(1);
                  st_q  <= ST_ADDR;
               end else begin
                  done_q <= 1'b1;
                  rd_q   <= wr_q ? '0 : rd_ext;
                  if (left_q == '0) begin
                     st_q <= ST_IDLE;
                  end else begin
                     left_q <= left_q - CNT_W'(1);
                     addr_q <= addr_q + DW'(step_of(size_q));
                     try_q  <= '0;
                     st_q   <= ST_ADDR;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign rd_data   = rd_q;
   assign err_retry = erty_q;
   assign err_tmo   = etmo_q;

   // R12
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xreq && !xack) |=> (xreq && $stable(xsel) && $stable(xwdata)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !cmd_valid) |=> cmd_ready);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   retry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_retry |-> (done && !err_tmo && cmd_ready));

   // R4
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_POLL) |-> (poll_q <= POLL_LAST));

   // R4
   tmo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_tmo |-> (done && cmd_ready));

endmodule

// File: rtl/dbg_dma_seq.sv
module dbg_dma_seq
   import dds_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int RETRY_MAX  = 10,
   parameter int POLL_LIMIT = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [31:0]      cmd_addr,
   input  logic [1:0]       cmd_size,
   input  logic             cmd_write,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic [31:0]      cmd_wdata,
   input  logic [31:0]      base_ctrl,
   output logic             xreq,
   output logic [1:0]       xsel,
   output logic [31:0]      xwdata,
   input  logic             xack,
   input  logic [31:0]      xrdata,
   output logic             done,
   output logic [31:0]      rd_data,
   output logic             err_retry,
   output logic             err_tmo
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (RETRY_MAX < 0) begin : g_bad_retry
      $error("RETRY_MAX must not be negative");
   end
   if (POLL_LIMIT < 1) begin : g_bad_poll
      $error("POLL_LIMIT must be at least 1");
   end
   if (DW != 32) begin : g_bad_dw
      $error("data path must be 32 bits");
   end

   logic [1:0]    lane_size, lane_off;
   logic [DW-1:0] lane_wdata, lane_raw, wr_rep, rd_ext;

   dds_seq #(
      .CNT_W      (CNT_W),
      .RETRY_MAX  (RETRY_MAX),
      .POLL_LIMIT (POLL_LIMIT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_addr   (cmd_addr),
      .cmd_size   (cmd_size),
      .cmd_write  (cmd_write),
      .cmd_count  (cmd_count),
      .cmd_wdata  (cmd_wdata),
      .base_ctrl  (base_ctrl),
      .lane_size  (lane_size),
      .lane_off   (lane_off),
      .lane_wdata (lane_wdata),
      .lane_raw   (lane_raw),
      .wr_rep     (wr_rep),
      .rd_ext     (rd_ext),
      .xreq       (xreq),
      .xsel       (xsel),
      .xwdata     (xwdata),
      .xack       (xack),
      .xrdata     (xrdata),
      .done       (done),
      .rd_data    (rd_data),
      .err_retry  (err_retry),
      .err_tmo    (err_tmo)
   );

   dds_lanes u_lanes (
      .size   (lane_size),
      .off    (lane_off),
      .wr_in  (lane_wdata),
      .raw    (lane_raw),
      .wr_rep (wr_rep),
      .rd_ext (rd_ext)
   );

endmodule

// File: tb/dbg_dma_seq_bench.sv
module dbg_dma_seq_bench;

   localparam int RMAX = 3;
   localparam int PLIM = 6;
   localparam logic [31:0] BASE = 32'h0100_0040;
   localparam logic [31:0] POLLV = BASE | 32'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_addr = '0;
   logic [1:0]  cmd_size = '0;
   logic        cmd_write = 1'b0;
   logic [3:0]  cmd_count = '0;
   logic [31:0] cmd_wdata = '0;
   logic        xreq;
   logic [1:0]  xsel;
   logic [31:0] xwdata;
   logic        xack = 1'b0;
   logic [31:0] xrdata = '0;
   logic        done;
   logic [31:0] rd_data;
   logic        err_retry, err_tmo;

   always #5 clk = ~clk;

   dbg_dma_seq #(.CNT_W(4), .RETRY_MAX(RMAX), .POLL_LIMIT(PLIM)) u_dbg_dma_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_write(cmd_write),
      .cmd_count(cmd_count), .cmd_wdata(cmd_wdata), .base_ctrl(BASE),
      .xreq(xreq), .xsel(xsel), .xwdata(xwdata), .xack(xack), .xrdata(xrdata),
      .done(done), .rd_data(rd_data), .err_retry(err_retry), .err_tmo(err_tmo));

   int n_run = 0, n_fail = 0, cyc = 0;

   // target model
   logic [31:0] mem [16];
   logic [31:0] t_addr = '0, t_data = '0;
   logic [1:0]  t_size = '0;
   logic        t_rd = 1'b0, t_err = 1'b0, stuck = 1'b0;
   int busy = 0, t_lat = 2, skip_n = 0, fail_n = 0, wait_c = 0, pat = 0;
   int hold_bad = 0, base_bad = 0;
   logic        hold_seen = 1'b0;
   logic [1:0]  h_sel = '0;
   logic [31:0] h_wd = '0;

   // trace and results
   logic [1:0]  tr_sel [256];
   logic [31:0] tr_wd  [256];
   logic [31:0] tr_rd  [256];
   int tr_n = 0, d_n = 0;
   logic [31:0] d_rd [16];
   logic        d_er [16];
   logic        d_et [16];

   function automatic logic [31:0] lmask(input int s, input int o);
      if (s == 0) return 32'hFF << (8 * o);
      if (s == 1) return 32'hFFFF << (16 * (o / 2));
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] rep(input int s, input logic [31:0] d);
      if (s == 0) return {4{d[7:0]}};
      if (s == 1) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic logic [31:0] pick(input int s, input int o, input logic [31:0] w);
      logic [31:0] v = w >> (8 * o);
      if (s == 0) return v & 32'hFF;
      if (s == 1) return v & 32'hFFFF;
      return w;
   endfunction

   task automatic complete_op();
      logic [31:0] m;
      if (skip_n > 0) skip_n--;
      else if (fail_n > 0) begin fail_n--; t_err = 1'b1; return; end
      if (t_rd) t_data = mem[t_addr[5:2]];
      else begin
         m = lmask(int'(t_size), int'(t_addr[1:0]));
         mem[t_addr[5:2]] = (mem[t_addr[5:2]] & ~m) | (t_data & m);
      end
   endtask

   task automatic exchange();
      case (xsel)
         2'd0: begin xrdata = t_addr; t_addr = xwdata; end
         2'd1: begin xrdata = t_data; t_data = xwdata; end
         default: begin
            xrdata = ((busy != 0) ? 32'h1 : 32'h0) | (t_err ? 32'h20 : 32'h0);
            if ((xwdata & BASE) != BASE) base_bad++;
            if (xwdata[4] && xwdata[0]) begin
               t_size = xwdata[3:2]; t_rd = xwdata[1]; busy = t_lat;
            end
            if (!xwdata[4]) t_err = 1'b0;
         end
      endcase
      if (tr_n < 256) begin
         tr_sel[tr_n] = xsel; tr_wd[tr_n] = xwdata; tr_rd[tr_n] = xrdata; tr_n++;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy > 0 && !stuck) begin
            busy--;
            if (busy == 0) complete_op();
         end
         if (xack) xack = 1'b0;
         else if (xreq) begin
            if (hold_seen && (xsel != h_sel || xwdata != h_wd)) hold_bad++;
            if (wait_c > 0) begin
               wait_c--; hold_seen = 1'b1; h_sel = xsel; h_wd = xwdata;
            end else begin
               exchange(); xack = 1'b1; hold_seen = 1'b0;
               pat = (pat + 1) % 3; wait_c = pat;
            end
         end
         if (done) begin
            if (d_n < 16) begin
               d_rd[d_n] = rd_data; d_er[d_n] = err_retry; d_et[d_n] = err_tmo;
            end
            d_n++;
         end
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] a, input int s, input logic w,
                        input int c, input logic [31:0] d);
      while (!cmd_ready) @(negedge clk);
      cmd_addr = a; cmd_size = 2'(s); cmd_write = w; cmd_count = 4'(c); cmd_wdata = d;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run(input logic [31:0] a, input int s, input logic w,
                      input int c, input logic [31:0] d, input int expd);
      tr_n = 0; d_n = 0;
      issue(a, s, w, c, d);
      while (d_n < expd) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   function automatic int addr_writes();
      int n = 0;
      for (int i = 0; i < tr_n; i++) if (tr_sel[i] == 2'd0) n++;
      return n;
   endfunction

   // R1 R2 R3 exact single-element order and control values
   task automatic chk_order(input string tag, input logic [31:0] a, input int s,
                            input logic w, input logic [31:0] d);
      int p = 0, np = 0, nset = 0;
      logic ok = 1'b1;
      logic [31:0] go = BASE | 32'h11 | (32'(s) << 2) | (w ? 32'h0 : 32'h2);
      if (tr_sel[p] != 2'd0 || tr_wd[p] != a) ok = 1'b0;
      p++;
      if (w) begin
         if (tr_sel[p] != 2'd1 || tr_wd[p] != rep(s, d)) ok = 1'b0;
         p++;
      end
      if (tr_sel[p] != 2'd2 || tr_wd[p] != go) ok = 1'b0;
      p++;
      while (p < tr_n && tr_sel[p] == 2'd2 && tr_wd[p] == POLLV) begin
         if (tr_rd[p][0]) nset++;
         p++; np++;
      end
      if (np == 0 || nset != np - 1) ok = 1'b0;
      if (!w) begin
         if (tr_sel[p] != 2'd1) ok = 1'b0;
         p++;
      end
      if (tr_sel[p] != 2'd2 || tr_wd[p] != BASE) ok = 1'b0;
      p++;
      if (p != tr_n) ok = 1'b0;
      chk(tag, {31'd0, ok}, 32'd1);
   endtask

   initial begin
      logic [31:0] a, d, old, w0;
      for (int i = 0; i < 16; i++) mem[i] = 32'hA1B2_C3D4 ^ (32'(i) * 32'h0107_0D13);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ready after reset", {31'd0, cmd_ready}, 32'd1);
      chk("R12 no request after reset", {31'd0, xreq}, 32'd0);
      chk("R11 done low after reset", {31'd0, done}, 32'd0);

      // size x offset x direction sweep
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o += (1 << s)) begin
               a = 32'(4 * (1 + s + 3 * w) + o);
               d = 32'h8765_4321 + 32'(s) * 32'h1111 + 32'(o) * 32'h0101;
               old = mem[a[5:2]];
               run(a, s, w[0], 1, d, 1);
               chk_order(w ? "R2 R3 write order" : "R1 R3 read order", a, s, w[0], d);
               chk("R11 one done", 32'(d_n), 32'd1);
               chk("R5 no error", {30'd0, d_er[0], d_et[0]}, 32'd0);
               if (w != 0)
                  chk("R8 replicated lanes", mem[a[5:2]],
                      (old & ~lmask(s, o)) | (rep(s, d) & lmask(s, o)));
               else if (s == 0) chk("R7 byte lane", d_rd[0], pick(s, o, old));
               else if (s == 1) chk("R6 half lane", d_rd[0], pick(s, o, old));
               else chk("R1 word data", d_rd[0], old);
            end

      // long poll: several polls, exit on first clear
      t_lat = 7;
      run(32'h18, 2, 1'b0, 1, 0, 1);
      chk_order("R4 poll exit order", 32'h18, 2, 1'b0, 0);
      chk("R4 poll data", d_rd[0], mem[6]);
      t_lat = 2;

      // retry succeeds on the last allowed attempt
      fail_n = RMAX;
      run(32'h8, 2, 1'b0, 1, 0, 1);
      chk("R5 restarts", 32'(addr_writes()), 32'(RMAX + 1));
      chk("R5 no error after retries", {31'd0, d_er[0]}, 32'd0);
      chk("R5 data after retries", d_rd[0], mem[2]);

      // retry limit exceeded by one
      fail_n = RMAX + 1;
      old = mem[12];
      run(32'h30, 2, 1'b1, 1, 32'hDEAD_0001, 1);
      chk("R5 attempts at limit", 32'(addr_writes()), 32'(RMAX + 1));
      chk("R5 error flag", {30'd0, d_er[0], d_et[0]}, 32'd2);
      chk("R5 memory untouched", mem[12], old);
      chk("R11 zero data on error", d_rd[0], 32'd0);

      // failure in the middle of a multi-element read
      skip_n = 1; fail_n = RMAX + 1;
      run(32'h0, 2, 1'b0, 3, 0, 2);
      chk("R9 stops after failure", 32'(d_n), 32'd2);
      chk("R9 first element", d_rd[0], mem[0]);
      chk("R5 second element error", {31'd0, d_er[1]}, 32'd1);
      chk("R9 address exchanges", 32'(addr_writes()), 32'(RMAX + 2));
      chk("R9 last address", tr_wd[tr_n - 1 - (tr_sel[tr_n-1] == 2'd0 ? 0 : 0)] & 32'h0, 32'h0);
      for (int i = tr_n - 1; i >= 0; i--)
         if (tr_sel[i] == 2'd0) begin
            chk("R9 no third address", tr_wd[i], 32'h4);
            break;
         end

      // multi-element byte read across a word boundary
      run(32'h3, 0, 1'b0, 5, 0, 5);
      for (int k = 0; k < 5; k++) begin
         a = 32'(3 + k);
         chk("R9 R7 byte stream", d_rd[k], pick(0, int'(a[1:0]), mem[a[5:2]]));
      end

      // multi-element halfword fill write
      old = mem[8];
      run(32'h22, 1, 1'b1, 3, 32'h1234_BEEF, 3);
      chk("R9 R8 half fill first word", mem[8], (old & 32'h0000_FFFF) | 32'hBEEF_0000);
      chk("R9 R8 half fill second word", mem[9], 32'hBEEF_BEEF);
      w0 = 32'd0;
      for (int i = 0; i < tr_n; i++)
         if (tr_sel[i] == 2'd1 && tr_wd[i] != 32'hBEEF_BEEF) w0 = tr_wd[i];
      chk("R8 data exchange values", w0, 32'd0);

      // count zero acts as one
      run(32'h14, 2, 1'b0, 0, 0, 1);
      chk("R9 count zero one element", 32'(d_n), 32'd1);
      chk("R9 count zero data", d_rd[0], mem[5]);

      // poll timeout
      stuck = 1'b1;
      run(32'h8, 2, 1'b0, 1, 0, 1);
      w0 = 32'd0;
      for (int i = 0; i < tr_n; i++) if (tr_sel[i] == 2'd2 && tr_wd[i] == POLLV) w0++;
      chk("R4 polls before timeout", w0, 32'(PLIM));
      chk("R4 timeout flag", {30'd0, d_er[0], d_et[0]}, 32'd1);
      chk("R4 clearing write last", tr_wd[tr_n - 1], BASE);
      chk("R4 no retry on timeout", 32'(addr_writes()), 32'd1);
      stuck = 1'b0; busy = 0;

      // command while busy is ignored
      old = mem[15];
      tr_n = 0; d_n = 0;
      issue(32'h4, 2, 1'b0, 1, 0);
      cmd_addr = 32'h3C; cmd_write = 1'b1; cmd_count = 4'd5; cmd_wdata = 32'h5555_AAAA;
      cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      while (d_n < 1) @(negedge clk);
      repeat (30) @(negedge clk);
      chk("R10 single done", 32'(d_n), 32'd1);
      chk("R10 single address", 32'(addr_writes()), 32'd1);
      chk("R10 address used", tr_wd[0], 32'h4);
      chk("R10 memory untouched", mem[15], old);

      chk("R12 held until ack", 32'(hold_bad), 32'd0);
      chk("R3 base bits present", 32'(base_bad), 32'd0);

      summary();
      $finish;
   end

endmodule